// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block picks which page frame to give up when a new page must be brought in. The frames form a ring, and a hand register points at the oldest candidate. Each frame carries one "recently used" flag. A one-cycle access strobe with a frame index raises that frame's flag.

When a victim is requested, the hand walks the ring and looks at one frame per clock. A frame whose flag is up loses the flag and is passed over. Passing over it has the same effect as moving it to the back of the queue, but no entry is moved. The first frame found with its flag down becomes the victim. The block reports it with a one-cycle completion pulse and parks the hand one step past it.

The victim index stays on its output until the next completion, so the requester can read it at leisure. If every flag is raised, one full revolution clears them all, and the frame the scan started from is chosen.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all used flags are 0, the hand is 0, `done` is 0 and `victim` is 0.
- R2: A cycle with `ref_valid`=1 sets the used flag of frame `ref_idx` (bit `ref_idx` of `used_flags`), visible after the next rising edge; other flags are unaffected by it.
- R3: During a scan exactly one frame, the one at `hand`, is examined per clock; if its flag is 1 the flag is cleared and the hand moves to the next frame.
- R4: The first examined frame whose flag is 0 is reported on `victim` with `done`=1; the latency from the edge that accepts `req` to the edge that raises `done` is (frames skipped + 1) cycles.
- R5: After a victim is chosen the hand points one past it, wrapping from NFRAMES-1 (15) to 0.
- R6: If all flags are 1 when the scan starts, the scan clears every flag and selects the starting frame after NFRAMES+1 (17) cycles.
- R7: If a reference to the frame being examined arrives in the same cycle that the scan would clear its flag, the flag stays 1.
- R8: `done` is a one-cycle pulse, `victim` changes only together with `done`, and `req` raised while a scan is running is ignored (no extra scan, no extra `done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Access strobe for frame `ref_idx` |
| ref_idx | input | 4 | Frame being accessed |
| req | input | 1 | Start a victim search (honoured when idle) |
| done | output | 1 | One-cycle pulse: `victim` is valid |
| victim | output | 4 | Chosen frame, held until the next `done` |
| hand | output | 4 | Current hand position |
| used_flags | output | 16 | Per-frame used flags, bit i for frame i |

## Verification
Random access bursts of varying density are applied between searches. Sparse bursts leave a clear frame near the hand, so those searches check the short path. Dense bursts force long runs of skipped frames, so those searches check that each skipped flag is cleared and that the latency matches the number of skips. A bench-side ring model predicts the victim, the latency, the resulting hand and the whole flag vector. Directed cases cover the full revolution when every flag is set, the hand wrapping past frame 15, and a reference that collides with the clear of the frame under the hand. A directed case also raises `req` in the middle of a scan; a stray second scan would show up as an extra pulse or as a change in the flags.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 16,
  localparam int IW = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid,
  input  logic [IW-1:0]      ref_idx,
  input  logic               req,
  output logic               done,
  output logic [IW-1:0]      victim,
  output logic [IW-1:0]      hand,
  output logic [NFRAMES-1:0] used_flags
);

  logic busy;

  wire [IW-1:0] hand_nx = (hand == IW'(NFRAMES - 1)) ? '0 : hand + 1'b1;
  wire          cur_used = used_flags[hand];
  wire          skip = busy && cur_used;
  wire          hit  = busy && !cur_used;

  for (genvar i = 0; i < NFRAMES; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        used_flags[i] <= 1'b0;
      else if (ref_valid && ref_idx == IW'(i))
        used_flags[i] <= 1'b1;
      else if (skip && hand == IW'(i))
        used_flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      victim <= '0;
      hand   <= '0;
    end else begin
      busy <= busy ? !hit : req;
      done <= hit;
      if (hit) victim <= hand;
      if (busy) hand <= hand_nx;
    end
  end

endmodule

module clock_victim_sel_chk #(
  parameter int NFRAMES = 16,
  localparam int IW = $clog2(NFRAMES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_valid,
  input logic [IW-1:0]      ref_idx,
  input logic               busy,
  input logic               done,
  input logic [IW-1:0]      victim,
  input logic [IW-1:0]      hand,
  input logic [NFRAMES-1:0] used_flags
);

  function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
    return (v == IW'(NFRAMES - 1)) ? '0 : v + 1'b1;
  endfunction

  assert_ref_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> used_flags[$past(ref_idx)]);

  assert_skip_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && used_flags[hand] && !(ref_valid && ref_idx == hand))
      |=> !used_flags[$past(hand)] && hand == step($past(hand)));

  assert_pick_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> victim == $past(hand) && !$past(used_flags[hand]));

  assert_hand_past_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hand == step(victim));

  assert_ref_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ref_valid && ref_idx == hand) |=> used_flags[$past(hand)]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_victim_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(victim) |-> done);

  assert_idle_hand_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(hand));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
  .busy(busy), .done(done), .victim(victim), .hand(hand),
  .used_flags(used_flags)
);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic [3:0] ref_idx = '0;
  logic req = 1'b0;
  logic done;
  logic [3:0] victim, hand;
  logic [N-1:0] used_flags;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] m_bits = '0;
  logic [3:0] m_hand = '0;
  logic [3:0] m_victim = '0;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .req(req), .done(done), .victim(victim), .hand(hand),
    .used_flags(used_flags)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scan model; prio keeps the start frame's flag set in the first examined cycle
  task automatic model_scan(input bit prio, output int lat);
    lat = 0;
    for (int s = 1; s <= 2 * N + 2; s++) begin
      lat = s;
      if (m_bits[m_hand]) begin
        if (!(prio && s == 1)) m_bits[m_hand] = 1'b0;
        m_hand = m_hand + 1'b1;
      end else begin
        m_victim = m_hand;
        m_hand = m_hand + 1'b1;
        break;
      end
    end
  endtask

  task automatic refs(input int cycles, input int density);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ref_valid = ($urandom % 100) < density;
      ref_idx = 4'($urandom);
      if (ref_valid) m_bits[ref_idx] = 1'b1;
    end
    @(negedge clk);
    ref_valid = 1'b0;
    @(negedge clk);
    chk("R2 flags after references", used_flags, m_bits);
  endtask

  task automatic search(input bit prio, input bit mid_req, input string tag);
    int exp_lat;
    int n;
    int pulses;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (prio) begin
      ref_valid = 1'b1;
      ref_idx = m_hand;
    end
    model_scan(prio, exp_lat);
    n = 0;
    while (!done && n < 3 * N) begin
      @(negedge clk);
      n++;
      ref_valid = 1'b0;
      req = (mid_req && n == 3);
    end
    req = 1'b0;
    chk({tag, " R4 done seen"}, done, 1);
    chk({tag, " R4 victim"}, victim, m_victim);
    chk({tag, " R4 latency"}, n, exp_lat);
    chk({tag, " R5 hand"}, hand, m_hand);
    chk({tag, " R3 flags"}, used_flags, m_bits);
    pulses = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk({tag, " R8 single pulse"}, pulses, 0);
    chk({tag, " R8 victim held"}, victim, m_victim);
    chk({tag, " R8 idle flags"}, used_flags, m_bits);
  endtask

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    chk("R1 flags", used_flags, 0);
    chk("R1 hand", hand, 0);
    chk("R1 done", done, 0);
    chk("R1 victim", victim, 0);
    rst_n = 1'b1;

    // all clear: pick frame 0 immediately
    search(1'b0, 1'b0, "empty");

    // all set: full revolution, req mid-scan ignored
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      ref_valid = 1'b1;
      ref_idx = 4'(i);
      m_bits[i] = 1'b1;
      @(negedge clk);
    end
    ref_valid = 1'b0;
    @(negedge clk);
    chk("R2 all set", used_flags, {N{1'b1}});
    search(1'b0, 1'b1, "R6 full-rev");

    // all set again, with a colliding reference on the start frame
    for (int i = 0; i < N; i++) begin
      ref_valid = 1'b1;
      ref_idx = 4'(i);
      m_bits[i] = 1'b1;
      @(negedge clk);
    end
    ref_valid = 1'b0;
    search(1'b1, 1'b0, "R7 collide");

    // drive hand near 15 to see the wrap
    while (m_hand != 4'd14) search(1'b0, 1'b0, "walk");
    refs(1, 0);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_idx = 4'd14;
    m_bits[14] = 1'b1;
    @(negedge clk);
    ref_valid = 1'b1;
    ref_idx = 4'd15;
    m_bits[15] = 1'b1;
    @(negedge clk);
    ref_valid = 1'b0;
    search(1'b0, 1'b0, "R5 wrap");

    // random traffic
    for (int t = 0; t < 120; t++) begin
      refs(1 + $urandom % 30, (t % 3 == 0) ? 90 : 30);
      search(1'b0, (t % 7) == 0, "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule